// File: doc/BRIEF.md
# Periodic SAR ADC Readout Sequencer

This block paces and reads out a serial successive-approximation converter whose conversion is started by the same framed clock burst that reads back the result. An internal sample-rate timer fires once per sample period, at either 1 kHz or 256 Hz as chosen by a select input. Each firing opens a frame: chip select goes low, the block drives a fixed burst of 24 serial clocks derived from the system clock, and it captures the converter's data line into a shift register.

When the frame closes, a 16-bit field taken from fixed positions of the captured word appears on the sample output, with a one-cycle valid strobe. If the timer fires while a frame is still open, that firing is discarded and a sticky overrun flag records it. The system clock frequency, the serial clock half-period, the burst length and the position of the result field are all parameters. An elaboration-time check rejects any configuration whose serial clock would exceed 2.9 MHz.

Top module: `adc_burst_seq`

## Requirements
- R1: With `rate_sel` = 0, successive falling edges of `adc_cs_n` are exactly SYS_CLK_HZ/1000 system cycles apart. With `rate_sel` = 1, they are SYS_CLK_HZ/256 cycles apart.
- R2: Every frame carries exactly BURST_LEN (default 24) rising edges of `adc_sclk`.
- R3: Each low and each high half of `adc_sclk` lasts HALF_DIV system cycles. `adc_sclk` never changes while `adc_cs_n` is high. Elaboration fails if SYS_CLK_HZ/(2*HALF_DIV) exceeds 2.9 MHz.
- R4: The first `adc_sclk` edge of a frame is a falling edge, HALF_DIV cycles after `adc_cs_n` falls. `adc_cs_n` rises HALF_DIV cycles after the last rising edge.
- R5: `adc_sdo` is captured on each `adc_sclk` rising edge, MSB first. The k-th captured bit (k = 0 first) lands at position BURST_LEN-1-k of the capture word. `sample` equals capture bits [RES_MSB : RES_MSB-15]. With the default RES_MSB = 22, `sample` bit 15 is the second bit captured.
- R6: `sample_valid` is high for exactly one system cycle. That cycle is the one in which `adc_cs_n` returns high, and `sample` changes only then.
- R7: A timer firing that arrives while a frame is open is dropped, so the next frame starts at the following firing. `overrun` then goes high and stays high until reset. At a sustainable rate, `overrun` stays low.
- R8: In the cycle after a synchronous active-high `rst` edge, even in mid-frame, `adc_cs_n` = 1, `adc_sclk` = 1, `sample_valid` = 0, `sample` = 0 and `overrun` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_sel | input | 1 | 0 selects the 1 kHz sample rate, 1 selects 256 Hz |
| adc_sdo | input | 1 | Serial data from the converter |
| adc_cs_n | output | 1 | Active-low converter chip select |
| adc_sclk | output | 1 | Serial clock, idle high |
| sample | output | 16 | Most recent converted result |
| sample_valid | output | 1 | One-cycle strobe marking a new result |
| overrun | output | 1 | Sticky flag: a timer firing was dropped |

## Verification
A wrong half-period counter shows at the pins within a single serial clock phase, as a stretched or shortened `adc_sclk` half. A wrong bit counter shows at the end of the first frame, as a clock count other than 24 or a frame that never closes. A slipped shift or a wrong field offset appears as a wrong `sample` value at the very first valid strobe. The bench therefore drives a different bit pattern into every frame, including all-ones, all-zeros and alternating words. A fault in the timer or in the drop logic shows within one or two sample periods, as a wrong distance between chip-select falling edges or a missing or spurious `overrun`.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_LEAD  = 2'd1,
        PH_CLOCK = 2'd2
    } burst_phase_e;

    localparam int SCLK_MAX_HZ = 2_900_000;

endpackage

// File: rtl/adc_rate_timer.sv
module adc_rate_timer #(
    parameter int FAST_CYC = 100_000,
    parameter int SLOW_CYC = 390_625
) (
    input  logic clk,
    input  logic rst,
    input  logic slow_sel,
    output logic tick
);

    localparam int MAX_CYC = (SLOW_CYC > FAST_CYC) ? SLOW_CYC : FAST_CYC;
    localparam int CW      = $clog2(MAX_CYC);
    localparam logic [CW-1:0] FAST_LAST = CW'(FAST_CYC - 1);
    localparam logic [CW-1:0] SLOW_LAST = CW'(SLOW_CYC - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          tick;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic [CW-1:0] limit;

    always_comb begin
        limit = slow_sel ? SLOW_LAST : FAST_LAST;
        tmr_d = tmr_q;
        tmr_d.tick = 1'b0;
        if (tmr_q.cnt >= limit) begin
            tmr_d.cnt  = '0;
            tmr_d.tick = 1'b1;
        end else begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign tick = tmr_q.tick;

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
        tmr_q.tick |=> !tmr_q.tick); // R1

endmodule

// File: rtl/adc_burst_engine.sv
module adc_burst_engine
    import adc_seq_pkg::*;
#(
    parameter int HALF_DIV  = 20,
    parameter int BURST_LEN = 24,
    parameter int DATA_W    = 16,
    parameter int RES_MSB   = 22
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              sdo,
    output logic              cs_n,
    output logic              sclk,
    output logic              busy,
    output logic [DATA_W-1:0] sample,
    output logic              sample_valid
);

    localparam int HW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam int BW = $clog2(BURST_LEN + 1);
    localparam logic [HW-1:0] HALF_LAST = HW'(HALF_DIV - 1);
    localparam logic [BW-1:0] BITS_ALL  = BW'(BURST_LEN);

    typedef struct packed {
        burst_phase_e          phase;
        logic                  cs_n;
        logic                  sclk;
        logic [HW-1:0]         hcnt;
        logic [BW-1:0]         bits;
        logic [BURST_LEN-1:0]  cap;
        logic [DATA_W-1:0]     sample;
        logic                  valid;
    } eng_t;

    localparam eng_t ENG_RESET = '{
        phase:  PH_IDLE,
        cs_n:   1'b1,
        sclk:   1'b1,
        hcnt:   '0,
        bits:   '0,
        cap:    '0,
        sample: '0,
        valid:  1'b0
    };

    eng_t eng_d, eng_q;
    logic half_done;

    always_comb begin
        eng_d       = eng_q;
        eng_d.valid = 1'b0;
        half_done   = (eng_q.hcnt == HALF_LAST);
        unique case (eng_q.phase)
            PH_IDLE: begin
                if (start) begin
                    eng_d.phase = PH_LEAD;
                    eng_d.cs_n  = 1'b0;
                    eng_d.hcnt  = '0;
                    eng_d.bits  = '0;
                end
            end
            PH_LEAD: begin
                if (half_done) begin
                    eng_d.phase = PH_CLOCK;
                    eng_d.sclk  = 1'b0;
                    eng_d.hcnt  = '0;
                end else begin
                    eng_d.hcnt = eng_q.hcnt + 1'b1;
                end
            end
            PH_CLOCK: begin
                if (!half_done) begin
                    eng_d.hcnt = eng_q.hcnt + 1'b1;
                end else begin
                    eng_d.hcnt = '0;
                    if (!eng_q.sclk) begin
                        eng_d.sclk = 1'b1;
                        eng_d.cap  = {eng_q.cap[BURST_LEN-2:0], sdo};
                        eng_d.bits = eng_q.bits + 1'b1;
                    end else if (eng_q.bits == BITS_ALL) begin
                        eng_d.phase  = PH_IDLE;
                        eng_d.cs_n   = 1'b1;
                        eng_d.sample = eng_q.cap[RES_MSB -: DATA_W];
                        eng_d.valid  = 1'b1;
                    end else begin
                        eng_d.sclk = 1'b0;
                    end
                end
            end
            default: eng_d = ENG_RESET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            eng_q <= ENG_RESET;
        end else begin
            eng_q <= eng_d;
        end
    end

    assign cs_n         = eng_q.cs_n;
    assign sclk         = eng_q.sclk;
    assign busy         = (eng_q.phase != PH_IDLE);
    assign sample       = eng_q.sample;
    assign sample_valid = eng_q.valid;

    AST_SCLK_FRAMED: assert property (@(posedge clk) disable iff (rst)
        !$stable(eng_q.sclk) |-> !eng_q.cs_n); // R3
    AST_BITS_BOUND: assert property (@(posedge clk) disable iff (rst)
        eng_q.bits <= BITS_ALL); // R2
    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
        eng_q.valid |=> !eng_q.valid); // R6
    AST_IDLE_SCLK_HIGH: assert property (@(posedge clk) disable iff (rst)
        eng_q.cs_n |-> eng_q.sclk); // R8

endmodule

// File: rtl/adc_burst_seq.sv
module adc_burst_seq
    import adc_seq_pkg::*;
#(
    parameter int SYS_CLK_HZ = 100_000_000,
    parameter int HALF_DIV   = 20,
    parameter int BURST_LEN  = 24,
    parameter int DATA_W     = 16,
    parameter int RES_MSB    = 22
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rate_sel,
    input  logic              adc_sdo,
    output logic              adc_cs_n,
    output logic              adc_sclk,
    output logic [DATA_W-1:0] sample,
    output logic              sample_valid,
    output logic              overrun
);

    localparam int FAST_CYC = SYS_CLK_HZ / 1000;
    localparam int SLOW_CYC = SYS_CLK_HZ / 256;
    localparam int SCLK_HZ  = SYS_CLK_HZ / (2 * HALF_DIV);

    if (SCLK_HZ > SCLK_MAX_HZ) begin : g_sclk_too_fast
        $error("serial clock above 2.9 MHz: raise HALF_DIV");
    end
    if (RES_MSB >= BURST_LEN || RES_MSB < DATA_W - 1) begin : g_bad_field
        $error("result field outside the capture word");
    end

    logic tick;
    logic busy;
    logic ovr_d, ovr_q;

    adc_rate_timer #(
        .FAST_CYC(FAST_CYC),
        .SLOW_CYC(SLOW_CYC)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .slow_sel (rate_sel),
        .tick     (tick)
    );

    adc_burst_engine #(
        .HALF_DIV (HALF_DIV),
        .BURST_LEN(BURST_LEN),
        .DATA_W   (DATA_W),
        .RES_MSB  (RES_MSB)
    ) u_engine (
        .clk          (clk),
        .rst          (rst),
        .start        (tick),
        .sdo          (adc_sdo),
        .cs_n         (adc_cs_n),
        .sclk         (adc_sclk),
        .busy         (busy),
        .sample       (sample),
        .sample_valid (sample_valid)
    );

    always_comb begin
        ovr_d = ovr_q | (tick & busy);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ovr_q <= 1'b0;
        end else begin
            ovr_q <= ovr_d;
        end
    end

    assign overrun = ovr_q;

    AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (tick && busy) |=> ovr_q); // R7
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
        ovr_q |=> ovr_q); // R7

endmodule

// File: tb/sim_adc_burst_seq.sv
module sim_adc_burst_seq;

    localparam int SYS_HZ = 256_000;
    localparam int HALF0  = 2;
    localparam int HALF1  = 6;
    localparam int P_FAST = SYS_HZ / 1000;
    localparam int P_SLOW = SYS_HZ / 256;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rate = 1'b0;
    logic sdo0 = 1'b0;
    logic sdo1 = 1'b0;
    logic rate1 = 1'b0;

    logic        cs0, sclk0, valid0, ovr0;
    logic [15:0] sample0;
    logic        cs1, sclk1, valid1, ovr1;
    logic [15:0] sample1;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    adc_burst_seq #(.SYS_CLK_HZ(SYS_HZ), .HALF_DIV(HALF0)) u0 (
        .clk(clk), .rst(rst), .rate_sel(rate), .adc_sdo(sdo0),
        .adc_cs_n(cs0), .adc_sclk(sclk0), .sample(sample0),
        .sample_valid(valid0), .overrun(ovr0)
    );

    adc_burst_seq #(.SYS_CLK_HZ(SYS_HZ), .HALF_DIV(HALF1)) u1 (
        .clk(clk), .rst(rst), .rate_sel(rate1), .adc_sdo(sdo1),
        .adc_cs_n(cs1), .adc_sclk(sclk1), .sample(sample1),
        .sample_valid(valid1), .overrun(ovr1)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] pattern(input int b);
        case (b)
            0: return 24'hFFFFFF;
            1: return 24'h000000;
            2: return 24'hAAAAAA;
            3: return 24'h555555;
            default: return 24'(b * 32'h009E3779 + 32'h005A5A5A);
        endcase
    endfunction

    // Converter model for u0: next bit after every falling serial clock edge
    logic [23:0] pat_cur = '0;
    int fidx = 0;
    always @(negedge sclk0) begin
        if (!cs0 && !rst && fidx < 24) begin
            sdo0 = pat_cur[23 - fidx];
            fidx++;
        end
    end

    // Monitor for u0
    int cyc = 0;
    logic p_cs = 1'b1, p_sclk = 1'b1;
    int fall_cyc = 0, edge_cyc = 0, rises = 0, nedge = 0, bursts0 = 0;
    bit have_fall = 0, skip = 0;
    always @(negedge clk) begin
        cyc++;
        if (rst) begin
            p_cs = 1'b1; p_sclk = 1'b1; have_fall = 0; nedge = 0;
        end else begin
            if (p_cs && !cs0) begin
                if (have_fall && !skip)
                    chk(cyc - fall_cyc == (rate ? P_SLOW : P_FAST), "R1 frame spacing",
                        cyc - fall_cyc, rate ? P_SLOW : P_FAST);
                skip = 0; have_fall = 1; fall_cyc = cyc; rises = 0; nedge = 0;
                pat_cur = pattern(bursts0); fidx = 0;
            end
            if (!cs0 && sclk0 != p_sclk) begin
                if (nedge == 0)
                    chk(!sclk0 && (cyc - fall_cyc == HALF0), "R4 lead before first edge",
                        cyc - fall_cyc, HALF0);
                else
                    chk(cyc - edge_cyc == HALF0, "R3 serial clock half period",
                        cyc - edge_cyc, HALF0);
                nedge++; edge_cyc = cyc;
                if (sclk0) rises++;
            end
            if (cs0 && sclk0 != p_sclk)
                chk(0, "R3 serial clock moved outside frame", sclk0, p_sclk);
            if (!p_cs && cs0) begin
                chk(rises == 24, "R2 clocks per frame", rises, 24);
                chk(cyc - edge_cyc == HALF0, "R4 trail after last edge", cyc - edge_cyc, HALF0);
                chk(valid0, "R6 valid with frame end", valid0, 1);
                chk(sample0 == pat_cur[22:7], "R5 sample value", sample0, pat_cur[22:7]);
                bursts0++;
            end else if (valid0) begin
                chk(0, "R6 valid outside frame end", valid0, 0);
            end
            p_cs = cs0; p_sclk = sclk0;
        end
    end

    // Monitor for u1 (burst longer than the fast period)
    logic q_cs = 1'b1, q_sclk = 1'b1;
    int fall1 = 0, rises1 = 0, bursts1 = 0;
    always @(negedge clk) begin
        if (rst) begin
            q_cs = 1'b1; q_sclk = 1'b1; bursts1 = 0;
        end else begin
            if (q_cs && !cs1) begin
                if (bursts1 == 0)
                    chk(!ovr1, "R7 no overrun before first drop", ovr1, 0);
                else
                    chk(cyc - fall1 == 2 * P_FAST, "R7 dropped firing spacing",
                        cyc - fall1, 2 * P_FAST);
                fall1 = cyc; rises1 = 0;
            end
            if (!cs1 && sclk1 && !q_sclk) rises1++;
            if (!q_cs && cs1) begin
                chk(rises1 == 24, "R2 clocks per frame, slow serial clock", rises1, 24);
                chk(ovr1, "R7 overrun raised and held", ovr1, 1);
                bursts1++;
            end
            q_cs = cs1; q_sclk = sclk1;
        end
    end

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        rst = 1'b1;
        repeat (5) @(negedge clk);
        chk(cs0 && sclk0, "R8 reset frame idle", {cs0, sclk0}, 3);
        chk(!valid0 && sample0 == 16'h0, "R8 reset result cleared", sample0, 0);
        chk(!ovr0 && !ovr1, "R8 reset overrun clear", {ovr0, ovr1}, 0);
        rst = 1'b0;

        while (bursts0 < 8) @(negedge clk);
        rate = 1'b1; skip = 1;
        while (bursts0 < 12) @(negedge clk);
        rate = 1'b0; skip = 1;
        while (bursts0 < 15) @(negedge clk);
        chk(!ovr0, "R7 no overrun at sustainable rate", ovr0, 0);
        while (bursts1 < 3) @(negedge clk);

        while (!(cs0 == 1'b0 && nedge > 5)) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(cs0 && sclk0, "R8 mid-frame reset idles pins", {cs0, sclk0}, 3);
        chk(!valid0 && sample0 == 16'h0, "R8 mid-frame reset clears result", sample0, 0);
        chk(!ovr1, "R8 reset clears sticky overrun", ovr1, 0);
        rst = 1'b0;
        begin
            int target = bursts0 + 2;
            while (bursts0 < target) @(negedge clk);
        end

        finished = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", bursts0, 17);
            summary();
            $finish;
        end
    end

endmodule